// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Tracker

This block keeps the single reservation that one hart holds between a load-reserved (LR) and its paired store-conditional (SC). An LR request records the cache line it addresses. A remote write (a store or an invalidation from another hart, seen on a snoop input) that lands on that line cancels the reservation. Each SC request then gets a registered verdict and a memory write-enable, and the write-enable is raised only when the SC succeeds.

The reservation works at cache-line granularity, with a 64-byte line by default. The low address bits inside a line play no part in any comparison. The hart's own plain stores never disturb the reservation, even when they fall on the reserved line, so false sharing inside a line cannot make an SC fail. Executing atomic memory operations, ordering annotations and the memory array itself are handled elsewhere.

Top module: `lrsc_resv_tracker`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, no reservation exists: `sc_done`, `sc_fail` and `mem_we` are 0, and an SC issued before any LR fails.
- R2: An LR records the line `addr[ADDR_W-1:6]` as reserved. An SC to that line with no conflict in between succeeds.
- R3: A snoop (`snp_req`) whose line equals the reserved line cancels the reservation, and a later SC fails. A snoop to the reserved line in the same cycle as the SC also makes that SC fail.
- R4: Own-hart stores (`st_req`) have no effect on the reservation, whatever their address, including addresses on the reserved line.
- R5: A failed SC never asserts `mem_we`.
- R6: Every cycle with `sc_req` high is answered one cycle later with `sc_done`=1 and `sc_fail`=0 on success or 1 on failure, and `mem_we` = `sc_done` AND NOT `sc_fail`. Cycles without an SC give all three outputs 0.
- R7: An SC cancels the reservation whether it succeeds or fails, so a second SC without a new LR fails.
- R8: An SC whose line differs from the reserved line fails.
- R9: Address bits [5:0] are ignored. An SC or snoop anywhere inside the reserved line counts as a match, and a snoop to any other line leaves the reservation intact.
- R10: A new LR replaces an existing reservation: an SC to the old line fails and an SC to the new line succeeds.
- R11: When an LR and an SC arrive in the same cycle, the SC is judged against the earlier reservation, and the LR's line is reserved afterwards. An LR arriving in the same cycle as a snoop to its own line still leaves that line reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lr_req | input | 1 | Load-reserved request |
| lr_addr | input | ADDR_W | Load-reserved byte address |
| sc_req | input | 1 | Store-conditional request |
| sc_addr | input | ADDR_W | Store-conditional byte address |
| st_req | input | 1 | Own-hart plain store |
| st_addr | input | ADDR_W | Own-hart plain store address |
| snp_req | input | 1 | Remote store or invalidation |
| snp_addr | input | ADDR_W | Remote write address |
| sc_done | output | 1 | SC verdict valid, one cycle after `sc_req` |
| sc_fail | output | 1 | 0 means success, 1 means failure |
| mem_we | output | 1 | Memory write-enable for a successful SC |

## Verification
The SC verdict is exercised with several directed sequences. A plain LR/SC pair sets the success path apart from failure. Snoops on the reserved line, on another line and in the same cycle as the SC separate cancellation from a miss. Own-hart stores on and off the reserved line show they are ignored. Back-to-back SCs, a mismatched SC, a replacing LR, and an LR arriving in the same cycle as an SC or a snoop pin down the clearing and priority rules. A long pseudo-random mix over a few nearby lines, with offsets inside each line, is then compared against a behavioural model on every clock, which exposes any offset bit that leaks into the comparison.

// File: rtl/lrsc_pkg.sv
// Shared types for the reservation tracker.
// Assumes: a single hart and a single reservation.
package lrsc_pkg;
    // Registered SC verdict
    typedef struct packed {
        logic done;
        logic fail;
        logic we;
    } sc_rsp_t;

    // Address probes compared against the reservation
    localparam int unsigned PROBE_SC  = 0;
    localparam int unsigned PROBE_SNP = 1;
    localparam int unsigned N_PROBES  = 2;
endpackage

// File: rtl/lrsc_line_cmp.sv
// Compares one address probe against the reserved line.
// Assumes: offset bits below the line size are ignored; the output is combinational.
module lrsc_line_cmp #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFFS_W = 6,
    localparam int unsigned LINE_W = ADDR_W - OFFS_W
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              resv_valid,
    input  logic [LINE_W-1:0] resv_line,
    output logic              hit
);
    logic [OFFS_W-1:0] unused_offs;
    assign unused_offs = addr[OFFS_W-1:0];

    // Hit when the probe is active and lands on the valid reserved line
    always_comb begin
        hit = en && resv_valid && (addr[ADDR_W-1:OFFS_W] == resv_line);
    end
endmodule

// File: rtl/lrsc_resv_reg.sv
// Holds the reservation: a valid bit and a line number.
// Assumes: set has priority over clear, so an LR always establishes its line.
module lrsc_resv_reg #(
    parameter int unsigned LINE_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set,
    input  logic [LINE_W-1:0] set_line,
    input  logic              clr,
    output logic              valid,
    output logic [LINE_W-1:0] line
);
    // Update the reservation on LR, SC or a conflicting snoop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            line  <= '0;
        end else if (set) begin
            valid <= 1'b1;
            line  <= set_line;
        end else if (clr) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/lrsc_sc_resolve.sv
// Turns an SC request into a registered verdict and write-enable.
// Assumes: sc_hit and snp_hit are computed against the reservation held before this edge.
module lrsc_sc_resolve
    import lrsc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sc_req,
    input  logic    sc_hit,
    input  logic    snp_hit,
    output sc_rsp_t rsp
);
    logic ok;

    // A same-cycle remote write to the line counts as arriving before the SC
    always_comb begin
        ok = sc_hit && !snp_hit;
    end

    // Register the verdict; quiet when there is no SC
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp <= '0;
        end else begin
            rsp.done <= sc_req;
            rsp.fail <= sc_req && !ok;
            rsp.we   <= sc_req && ok;
        end
    end
endmodule

// File: rtl/lrsc_resv_tracker.sv
// Top: LR/SC reservation tracker for one hart, working on whole cache lines.
// Assumes: at most one LR, SC, own store and snoop per cycle; own stores are
// ignored on purpose.
module lrsc_resv_tracker
    import lrsc_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned LINE_BYTES = 64,
    localparam int unsigned OFFS_W    = $clog2(LINE_BYTES),
    localparam int unsigned LINE_W    = ADDR_W - OFFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lr_req,
    input  logic [ADDR_W-1:0] lr_addr,
    input  logic              sc_req,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic              st_req,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              snp_req,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              sc_done,
    output logic              sc_fail,
    output logic              mem_we
);
    logic              resv_valid;
    logic [LINE_W-1:0] resv_line;
    logic [N_PROBES-1:0] probe_en;
    logic [ADDR_W-1:0]   probe_addr [N_PROBES];
    logic [N_PROBES-1:0] probe_hit;
    sc_rsp_t           rsp;
    logic              unused_own;
    logic [OFFS_W-1:0] unused_lr_offs;

    // Own-hart stores never touch the reservation
    assign unused_own     = st_req ^ (^st_addr);
    assign unused_lr_offs = lr_addr[OFFS_W-1:0];

    // Route the SC and snoop addresses to the line comparators
    always_comb begin
        probe_en[PROBE_SC]    = sc_req;
        probe_addr[PROBE_SC]  = sc_addr;
        probe_en[PROBE_SNP]   = snp_req;
        probe_addr[PROBE_SNP] = snp_addr;
    end

    for (genvar g = 0; g < N_PROBES; g++) begin : g_probe
        lrsc_line_cmp #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_cmp (
            .en         (probe_en[g]),
            .addr       (probe_addr[g]),
            .resv_valid (resv_valid),
            .resv_line  (resv_line),
            .hit        (probe_hit[g])
        );
    end

    lrsc_resv_reg #(.LINE_W(LINE_W)) u_resv (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (lr_req),
        .set_line (lr_addr[ADDR_W-1:OFFS_W]),
        .clr      (sc_req || probe_hit[PROBE_SNP]),
        .valid    (resv_valid),
        .line     (resv_line)
    );

    lrsc_sc_resolve u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .sc_req  (sc_req),
        .sc_hit  (probe_hit[PROBE_SC]),
        .snp_hit (probe_hit[PROBE_SNP]),
        .rsp     (rsp)
    );

    assign sc_done = rsp.done;
    assign sc_fail = rsp.fail;
    assign mem_we  = rsp.we;
endmodule

// File: rtl/lrsc_resv_tracker_chk.sv
// Checker for the reservation tracker, holding its own shadow of the reservation.
// Assumes: bound to lrsc_resv_tracker with default parameters or matching ones.
module lrsc_resv_tracker_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFFS_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lr_req,
    input logic [ADDR_W-1:0] lr_addr,
    input logic              sc_req,
    input logic [ADDR_W-1:0] sc_addr,
    input logic              snp_req,
    input logic [ADDR_W-1:0] snp_addr,
    input logic              sc_done,
    input logic              sc_fail,
    input logic              mem_we
);
    logic                     sh_v;
    logic [ADDR_W-OFFS_W-1:0] sh_line;
    logic                     exp_ok;

    // Shadow reservation and expected SC verdict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_v    <= 1'b0;
            sh_line <= '0;
            exp_ok  <= 1'b0;
        end else begin
            exp_ok <= sh_v && (sc_addr[ADDR_W-1:OFFS_W] == sh_line) &&
                      !(snp_req && snp_addr[ADDR_W-1:OFFS_W] == sh_line);
            if (lr_req) begin
                sh_v    <= 1'b1;
                sh_line <= lr_addr[ADDR_W-1:OFFS_W];
            end else if (sc_req || (snp_req && snp_addr[ADDR_W-1:OFFS_W] == sh_line)) begin
                sh_v <= 1'b0;
            end
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!sc_done && !sc_fail && !mem_we));

    // R5
    fail_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_done && sc_fail) |-> !mem_we);

    // R6
    sc_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_req |=> sc_done);

    // R6
    we_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> sc_done);

    // R3
    verdict_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_done |-> (sc_fail == !exp_ok));
endmodule

bind lrsc_resv_tracker lrsc_resv_tracker_chk #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lr_req   (lr_req),
    .lr_addr  (lr_addr),
    .sc_req   (sc_req),
    .sc_addr  (sc_addr),
    .snp_req  (snp_req),
    .snp_addr (snp_addr),
    .sc_done  (sc_done),
    .sc_fail  (sc_fail),
    .mem_we   (mem_we)
);

// File: tb/test_lrsc_resv_tracker.sv
// Bench: behavioural reference model compared with the outputs on every clock.
module test_lrsc_resv_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lr_req = 1'b0, sc_req = 1'b0, st_req = 1'b0, snp_req = 1'b0;
    logic [31:0] lr_addr = '0, sc_addr = '0, st_addr = '0, snp_addr = '0;
    logic        sc_done, sc_fail, mem_we;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    // Reference model state
    bit          m_v = 0;
    int unsigned m_line = 0;
    bit          e_done = 0, e_fail = 0, e_we = 0;

    always #2.5 clk = ~clk;

    lrsc_resv_tracker i_lrsc_resv_tracker (
        .clk(clk), .rst_n(rst_n),
        .lr_req(lr_req), .lr_addr(lr_addr),
        .sc_req(sc_req), .sc_addr(sc_addr),
        .st_req(st_req), .st_addr(st_addr),
        .snp_req(snp_req), .snp_addr(snp_addr),
        .sc_done(sc_done), .sc_fail(sc_fail), .mem_we(mem_we)
    );

    task automatic check(input string tag);
        tests++;
        if (sc_done !== e_done || sc_fail !== e_fail || mem_we !== e_we) begin
            fails++;
            $display("FAIL %s: got done=%b fail=%b we=%b, expected done=%b fail=%b we=%b",
                     tag, sc_done, sc_fail, mem_we, e_done, e_fail, e_we);
        end
    endtask

    // One clock: drive at negedge, advance the model at posedge, compare after it
    task automatic cyc(input bit lr, input int unsigned la,
                       input bit sc, input int unsigned sa,
                       input bit st, input int unsigned sta,
                       input bit sn, input int unsigned sna,
                       input string tag);
        @(negedge clk);
        lr_req = lr; lr_addr = la; sc_req = sc; sc_addr = sa;
        st_req = st; st_addr = sta; snp_req = sn; snp_addr = sna;
        @(posedge clk);
        if (!rst_n) begin
            m_v = 0; e_done = 0; e_fail = 0; e_we = 0;
        end else begin
            bit snp_hit;
            bit ok;
            snp_hit = sn && m_v && ((sna >> 6) == m_line);
            ok = m_v && ((sa >> 6) == m_line) && !snp_hit;
            e_done = sc;
            e_fail = sc && !ok;
            e_we   = sc && ok;
            if (lr) begin
                m_v = 1; m_line = la >> 6;
            end else if (sc || snp_hit) begin
                m_v = 0;
            end
        end
        #1;
        check(tag);
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic lr(input int unsigned a, input string tag);
        cyc(1, a, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic sc(input int unsigned a, input string tag);
        cyc(0, 0, 1, a, 0, 0, 0, 0, tag);
    endtask

    localparam int unsigned LA = 32'h0000_1000;
    localparam int unsigned LB = 32'h0000_1040;
    localparam int unsigned LC = 32'h0000_2000;

    initial begin
        // R1: reset state
        idle("R1 in reset");
        idle("R1 in reset");
        @(negedge clk); rst_n = 1'b1;
        sc(LA, "R1 SC before LR");
        idle("R1 fail response");

        // R2 and R9: success with an offset inside the line
        lr(LA + 4, "R2 LR");
        sc(LA + 32'h3c, "R2 SC same line");
        idle("R2 R9 success");

        // R4: own stores on and off the reserved line
        lr(LA, "R4 LR");
        cyc(0, 0, 0, 0, 1, LA, 0, 0, "R4 own store same word");
        cyc(0, 0, 0, 0, 1, LA + 8, 0, 0, "R4 own store same line");
        cyc(0, 0, 0, 0, 1, LB, 0, 0, "R4 own store other line");
        sc(LA, "R4 SC");
        idle("R4 success");

        // R3: snoop hit cancels
        lr(LA, "R3 LR");
        cyc(0, 0, 0, 0, 0, 0, 1, LA + 8, "R3 snoop hit");
        sc(LA, "R3 SC");
        idle("R3 R5 fail, no write");

        // R9: snoop to another line is harmless
        lr(LA, "R9 LR");
        cyc(0, 0, 0, 0, 0, 0, 1, LB, "R9 snoop miss");
        sc(LA, "R9 SC");
        idle("R9 success");

        // R7: second SC fails
        lr(LA, "R7 LR");
        sc(LA, "R7 first SC");
        sc(LA, "R7 first SC success");
        idle("R7 second SC fails");

        // R8: SC to other line fails and clears
        lr(LA, "R8 LR");
        sc(LB, "R8 SC other line");
        sc(LA, "R8 fail");
        idle("R7 after failed SC");

        // R10: new LR replaces
        lr(LA, "R10 LR old");
        lr(LB, "R10 LR new");
        sc(LA, "R10 SC old");
        lr(LB, "R10 old fails");
        sc(LB + 1, "R10 SC new");
        idle("R10 new succeeds");

        // R3: snoop in same cycle as SC
        lr(LA, "R3 LR");
        cyc(0, 0, 1, LA, 0, 0, 1, LA, "R3 SC with snoop");
        idle("R3 same-cycle snoop fails");

        // R11: LR with SC in the same cycle
        lr(LA, "R11 LR A");
        cyc(1, LB, 1, LA, 0, 0, 0, 0, "R11 LR B with SC A");
        sc(LB, "R11 SC A judged on A");
        idle("R11 SC B succeeds");

        // R11: LR with snoop to the same line
        cyc(1, LC, 0, 0, 0, 0, 1, LC, "R11 LR with snoop");
        sc(LC, "R11 SC");
        idle("R11 reservation kept");

        // Pseudo-random mix over a few lines
        begin
            int unsigned s = 32'h1234_5678;
            int unsigned pick [4] = '{LA, LA + 32'h24, LB, LC};
            for (int i = 0; i < 600; i++) begin
                s ^= s << 13; s ^= s >> 17; s ^= s << 5;
                cyc(s[0] & s[1], pick[s[3:2]], s[4] & s[5], pick[s[7:6]],
                    s[8], pick[s[10:9]], s[11] & s[12] & s[13], pick[s[15:14]],
                    "R2 R3 R6 random mix");
            end
        end
        idle("R6 drain");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule